// File: doc/BRIEF.md
# Manchester Auxiliary Channel Preamble Transmitter

This block drives the opening of a request on a differential auxiliary channel. A start strobe arms it. On each following pulse of a clock-enable tick that runs at twice the bit rate, it steps the line through one half-bit. It first sends a run of Manchester-II encoded zero bits. That run is the active precharge followed by the leading zeros of the sync pattern. The block then closes the sync pattern with two bit periods high and two bit periods low. After that it pulses a done flag, and the payload serializer takes the line from there.

The length of the zero run comes from a register field. The field counts extra precharge time in 2 microsecond steps. With a nominal bit period of 1 microsecond, each step adds two zero bits on top of a fixed base of 26. The total run may not exceed 32 zeros. A field value that would exceed this is cut back to 32, and a sticky flag records the misconfiguration.

Top module: `aux_preamble_tx`

## Requirements
- R1: While reset is high and immediately after it, line_o, drive_en_o, done_o and cfg_violation_o are all 0.
- R2: Every zero bit of the run is sent as two half-bits: line_o is 0 in the first half-bit and 1 in the second.
- R3: The zero run holds BASE_ZEROS + 2*precharge_field zero bits (26 + 2*field by default), sampled when the start strobe is accepted. A later change of the field has no effect on a run that has already begun.
- R4: When 26 + 2*field exceeds MAX_ZEROS (32), the run is clamped to 32 zeros and cfg_violation_o goes to 1. The flag stays at 1 until reset.
- R5: After the zero run, line_o is 1 for four half-bits and then 0 for four half-bits.
- R6: On the tick that follows the last half-bit, done_o is 1 for exactly one clock cycle. In that same cycle drive_en_o falls to 0 and line_o is 0.
- R7: An accepted start changes no output by itself. drive_en_o rises on the first tick after start, together with the first half-bit, which is low.
- R8: line_o and drive_en_o change only on clock edges where tick_i is 1.
- R9: A start strobe seen while a preamble is armed or running is ignored. It does not alter the current sequence and does not queue a second one.
- R10: Whenever drive_en_o is 0, line_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a preamble, accepted when idle |
| tick_i | input | 1 | Clock enable at twice the bit rate, one half-bit per pulse |
| precharge_field_i | input | FIELD_W | Extra precharge time in 2 microsecond units |
| line_o | output | 1 | Encoded line level |
| drive_en_o | output | 1 | Transmitter drive enable |
| done_o | output | 1 | One-cycle pulse when the preamble has ended |
| cfg_violation_o | output | 1 | Sticky flag: a field value asked for more than MAX_ZEROS zeros |

## Verification
The bench sweeps every field value in ascending order and checks each half-bit against a length of min(26 + 2*field, 32). A design that ignores the clamp runs too long at field 4 and above. A design that drops the stickiness, or sets the flag one value early, shows a wrong flag at field 3 or 4. The bench changes the field right after start and pulses start again in the middle of a run. A design that samples the field late, or restarts on the second strobe, sends a different length or begins an extra sequence. It also checks that the line holds still on cycles without a tick, and that done lasts exactly one cycle and drops drive enable with it. A design that gets these wrong shows a moving line between ticks, or a done that is too long or misplaced.

// File: rtl/aux_pre_pkg.sv
package aux_pre_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } pre_state_t;

endpackage

// File: rtl/aux_pre_len.sv
module aux_pre_len #(
  parameter int FIELD_W    = 4,
  parameter int BASE_ZEROS = 26,
  parameter int MAX_ZEROS  = 32,
  parameter int CNT_W      = 6
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [CNT_W-1:0]   zeros_o,
  output logic               over_o
);
  localparam int RAW_W = FIELD_W + CNT_W + 1;

  logic [RAW_W-1:0] raw;

  always_comb begin
    raw    = RAW_W'(BASE_ZEROS) + (RAW_W'(field_i) << 1);
    over_o = raw > RAW_W'(MAX_ZEROS);
    if (over_o) zeros_o = CNT_W'(MAX_ZEROS);
    else        zeros_o = raw[CNT_W-1:0];
  end
endmodule

// File: rtl/aux_pre_enc.sv
module aux_pre_enc #(
  parameter int POS_W   = 7,
  parameter int CNT_W   = 6,
  parameter int HI_BITS = 2,
  parameter int LO_BITS = 2
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [CNT_W-1:0] zeros_i,
  output logic             level_o,
  output logic             last_o
);
  logic [POS_W-1:0] zero_end;
  logic [POS_W-1:0] hi_end;
  logic [POS_W-1:0] all_end;

  always_comb begin
    zero_end = POS_W'(zeros_i) << 1;
    hi_end   = zero_end + POS_W'(2 * HI_BITS);
    all_end  = hi_end + POS_W'(2 * LO_BITS);
    if (pos_i < zero_end)    level_o = pos_i[0];
    else if (pos_i < hi_end) level_o = 1'b1;
    else                     level_o = 1'b0;
    last_o = (pos_i == all_end - POS_W'(1));
  end
endmodule

// File: rtl/aux_preamble_tx.sv
module aux_preamble_tx #(
  parameter int FIELD_W    = 4,
  parameter int BASE_ZEROS = 26,
  parameter int MAX_ZEROS  = 32,
  parameter int HI_BITS    = 2,
  parameter int LO_BITS    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               tick_i,
  input  logic [FIELD_W-1:0] precharge_field_i,
  output logic               line_o,
  output logic               drive_en_o,
  output logic               done_o,
  output logic               cfg_violation_o
);
  import aux_pre_pkg::*;

  localparam int CNT_W = $clog2(MAX_ZEROS + 1);
  localparam int POS_W = $clog2(2 * (MAX_ZEROS + HI_BITS + LO_BITS) + 1);

  pre_state_t        state;
  logic [CNT_W-1:0]  zeros_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  pos_nx;
  logic [CNT_W-1:0]  zeros_calc;
  logic              over_calc;
  logic              lvl_nx;
  logic              last_cur;
  logic              lvl_dummy_last;
  logic              lvl_cur_unused;

  aux_pre_len #(
    .FIELD_W(FIELD_W), .BASE_ZEROS(BASE_ZEROS),
    .MAX_ZEROS(MAX_ZEROS), .CNT_W(CNT_W)
  ) u_len (
    .field_i(precharge_field_i),
    .zeros_o(zeros_calc),
    .over_o (over_calc)
  );

  // Level of the half-bit about to be entered.
  aux_pre_enc #(
    .POS_W(POS_W), .CNT_W(CNT_W), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS)
  ) u_enc_next (
    .pos_i  (pos_nx),
    .zeros_i(zeros_q),
    .level_o(lvl_nx),
    .last_o (lvl_dummy_last)
  );

  // End-of-sequence detect on the half-bit now on the line.
  aux_pre_enc #(
    .POS_W(POS_W), .CNT_W(CNT_W), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS)
  ) u_enc_cur (
    .pos_i  (pos_q),
    .zeros_i(zeros_q),
    .level_o(lvl_cur_unused),
    .last_o (last_cur)
  );

  always_comb begin
    if (state == ST_RUN) pos_nx = pos_q + POS_W'(1);
    else                 pos_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      zeros_q         <= '0;
      pos_q           <= '0;
      line_o          <= 1'b0;
      drive_en_o      <= 1'b0;
      done_o          <= 1'b0;
      cfg_violation_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            zeros_q <= zeros_calc;
            if (over_calc) cfg_violation_o <= 1'b1;
            state <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (tick_i) begin
            pos_q      <= pos_nx;
            line_o     <= lvl_nx;
            drive_en_o <= 1'b1;
            state      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            if (last_cur) begin
              line_o     <= 1'b0;
              drive_en_o <= 1'b0;
              done_o     <= 1'b1;
              pos_q      <= '0;
              state      <= ST_IDLE;
            end else begin
              pos_q  <= pos_nx;
              line_o <= lvl_nx;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_preamble_tx_chk.sv
module aux_preamble_tx_chk #(
  parameter int BASE_ZEROS = 26,
  parameter int MAX_ZEROS  = 32,
  parameter int HI_BITS    = 2,
  parameter int LO_BITS    = 2
) (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic line_o,
  input logic drive_en_o,
  input logic done_o,
  input logic cfg_violation_o
);
  localparam int HB_MIN = 2 * (BASE_ZEROS + HI_BITS + LO_BITS);
  localparam int HB_MAX = 2 * (MAX_ZEROS + HI_BITS + LO_BITS);

  logic [9:0] hb_cnt;

  always_ff @(posedge clk) begin
    if (rst || !drive_en_o) hb_cnt <= '0;
    else if (tick_i)        hb_cnt <= hb_cnt + 10'd1;
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_done_release: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!drive_en_o && !line_o));

  a_r4_sticky_flag: assert property (@(posedge clk) disable iff (rst)
    cfg_violation_o |=> cfg_violation_o);

  a_r4_len_window: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (hb_cnt >= 10'(HB_MIN) && hb_cnt <= 10'(HB_MAX)));

  a_r7_first_half_low: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_en_o) |-> !line_o);

  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_i) |-> ($stable(line_o) && $stable(drive_en_o)));

  a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
    !drive_en_o |-> !line_o);
endmodule

bind aux_preamble_tx aux_preamble_tx_chk #(
  .BASE_ZEROS(BASE_ZEROS), .MAX_ZEROS(MAX_ZEROS),
  .HI_BITS(HI_BITS), .LO_BITS(LO_BITS)
) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .line_o(line_o),
  .drive_en_o(drive_en_o), .done_o(done_o), .cfg_violation_o(cfg_violation_o)
);

// File: tb/sim_aux_preamble_tx.sv
module sim_aux_preamble_tx;
  localparam int FIELD_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic tick_i = 1'b0;
  logic [FIELD_W-1:0] field = '0;
  logic line_o, drive_en_o, done_o, cfg_violation_o;

  int checks = 0;
  int errors = 0;
  bit vexp = 1'b0;

  always #5 clk = ~clk;

  aux_preamble_tx #(.FIELD_W(FIELD_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
    .precharge_field_i(field), .line_o(line_o), .drive_en_o(drive_en_o),
    .done_o(done_o), .cfg_violation_o(cfg_violation_o)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic run_seq(input int f, input bit inject);
    int n, total, exp_line, held;
    n = 26 + 2 * f;
    if (n > 32) begin n = 32; vexp = 1'b1; end
    total = 2 * n + 8;
    @(negedge clk) begin start_i = 1'b1; field = FIELD_W'(f); end
    @(negedge clk) begin start_i = 1'b0; field = ~FIELD_W'(f); end
    chk("R7", drive_en_o, 0, "drive before first tick");
    chk("R4", cfg_violation_o, vexp, "flag after start");
    for (int h = 0; h < total; h++) begin
      pulse_tick();
      if (h < 2 * n)          exp_line = h % 2;
      else if (h < 2 * n + 4) exp_line = 1;
      else                    exp_line = 0;
      chk(h < 2 * n ? "R2_R3" : "R5", line_o, exp_line, $sformatf("line f=%0d h=%0d", f, h));
      chk("R7", drive_en_o, 1, "drive during run");
      if (done_o) chk("R6", done_o, 0, "early done");
      held = line_o;
      if (inject && h == 5) begin
        @(negedge clk) begin start_i = 1'b1; field = '0; end
        @(negedge clk) start_i = 1'b0;
      end else begin
        @(negedge clk);
      end
      chk("R8", line_o, held, "line between ticks");
      if (inject && h == 5) chk("R9", drive_en_o, 1, "busy start");
    end
    pulse_tick();
    chk("R6", done_o, 1, $sformatf("done f=%0d", f));
    chk("R6", drive_en_o, 0, "drive at done");
    chk("R10", line_o, 0, "line at done");
    @(negedge clk);
    chk("R6", done_o, 0, "done width");
    chk("R4", cfg_violation_o, vexp, $sformatf("flag f=%0d", f));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", line_o, 0, "reset line");
    chk("R1", drive_en_o, 0, "reset drive");
    chk("R1", done_o, 0, "reset done");
    chk("R1", cfg_violation_o, 0, "reset flag");
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1", drive_en_o, 0, "after reset drive");
    // Ticks with no start: nothing moves (R10)
    for (int k = 0; k < 3; k++) begin
      pulse_tick();
      chk("R10", drive_en_o, 0, "idle drive");
      chk("R10", line_o, 0, "idle line");
    end
    for (int f = 0; f < (1 << FIELD_W); f++) run_seq(f, 1'b0);
    // Busy start ignored, no queued run (R9)
    run_seq(1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      pulse_tick();
      chk("R9", drive_en_o, 0, "no queued run");
    end
    // Flag cleared only by reset (R4)
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    vexp = 1'b0;
    chk("R4", cfg_violation_o, 0, "flag cleared by reset");
    run_seq(3, 1'b0);
    run_seq(5, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule